// File: doc/BRIEF.md
# Identifier Acceptance Filter Table

This block decides whether a received frame on a controller-area bus is kept, and if so, which filter entry let it through. A small table of 32-bit filter words is loaded through a write port. One format select decides how every word of the table is read. A word can hold one whole identifier, two 14-bit identifier slices, or four 8-bit identifier slices. The same table therefore offers a few wide filters or many narrow ones. All entries are compared in parallel. The lowest-numbered entry that matches wins. One clock after the frame's valid strobe, an accept pulse is raised and the winning index is reported.

Every compared bit is qualified by a mask. By default one global mask word applies to all entries. When individual masking is on, the first entries (their count is a configuration field) each use a mask register of their own. Entries beyond that count keep using the global mask. Bit timing, frame reception and message storage belong to neighbouring blocks.

Top module: `acfFilter`

## Requirements
- R1: `cfgFormat` selects how the table is read: 0 gives one entry per word (NUM_WORDS entries), 1 gives two per word (2*NUM_WORDS), 2 gives four per word (4*NUM_WORDS). Entry index = word*slicesPerWord + slot, and slot k sits at bits [14k+13:14k] for format 1 and [8k+7:8k] for format 2.
- R2: Format 0 compares word bit 30 with `frmRemote`, bit 29 with `frmExt`, and bits [28:0] with the identifier. For an extended frame the identifier is `frmId`. For a standard frame it is `frmId[10:0]` zero-extended, so `frmId[28:11]` is ignored.
- R3: Format 1 compares slot bit 13 with `frmRemote`, bit 12 with `frmExt`, and bits [11:0] with `frmId[28:17]` for extended frames or with {`frmId[10:0]`, 0} for standard frames.
- R4: Format 2 compares the 8-bit slot with `frmId[28:21]` for extended frames or with `frmId[10:3]` for standard frames. The remote flag is not compared.
- R5: Format code 3 accepts no frame, and `hitIndex` keeps its value.
- R6: A mask bit of 1 requires the frame bit to equal the filter bit. A mask bit of 0 ignores that bit. The mask bits used for an entry are the same bit positions as its filter field.
- R7: With `cfgIndivEn` high, entry e uses mask register e when e < `cfgIndivCount` and e < NUM_IMASK. A count above NUM_IMASK acts as NUM_IMASK.
- R8: With `cfgIndivEn` low, or for entries outside the individually masked range, `cfgGlobalMask` is used.
- R9: When several entries match, the lowest index is reported.
- R10: `hitValid` is high for exactly the one cycle after a cycle with `frmValid` high and at least one match. It is never high otherwise.
- R11: `hitIndex` resets to 0, loads the winning index when a frame is accepted, and otherwise holds its value.
- R12: A table or mask write takes effect for a frame presented in the cycle after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgFormat | input | 2 | Table read format (0 whole, 1 two slots, 2 four slots, 3 none) |
| cfgIndivEn | input | 1 | Enable individual masks |
| cfgIndivCount | input | $clog2(NUM_IMASK+1) | Number of entries with their own mask |
| cfgGlobalMask | input | 32 | Mask word for entries without an individual mask |
| tblWrEn | input | 1 | Table word write strobe |
| tblWrAddr | input | $clog2(NUM_WORDS) | Table word address |
| tblWrData | input | 32 | Table word data |
| maskWrEn | input | 1 | Individual mask write strobe |
| maskWrAddr | input | $clog2(NUM_IMASK) | Individual mask address |
| maskWrData | input | 32 | Individual mask data |
| frmValid | input | 1 | Frame identifier valid strobe |
| frmId | input | 29 | Frame identifier |
| frmExt | input | 1 | Extended identifier flag |
| frmRemote | input | 1 | Remote request flag |
| hitValid | output | 1 | Accept pulse |
| hitIndex | output | $clog2(4*NUM_WORDS) | Index of the matching entry |

## Verification
The embedded assertions watch properties that hold on every cycle. An accept pulse only follows a valid strobe, format 3 never produces one, the index holds between acceptances, and a loaded index always lies inside the entry count of the active format. Whether the reported index is the correct one cannot be stated as a simple property. This covers slot extraction per format, the standard or extended key mapping, the choice between individual and global masks, lowest-index priority and write-then-use ordering. Those are shown only by the bench. It sweeps every standard identifier and a set of extended identifiers through each format and mask configuration and compares the results against an arithmetic model.

// File: rtl/acfPkg.sv
package acfPkg;
  typedef enum logic [1:0] {
    FMT_WHOLE   = 2'd0,
    FMT_HALF    = 2'd1,
    FMT_QUARTER = 2'd2,
    FMT_NONE    = 2'd3
  } fmtSel_t;

  typedef struct packed {
    logic tblWe;
    logic maskWe;
    logic evalFrame;
    logic loadHit;
  } ctrlStrobes_t;
endpackage

// File: rtl/acfCtrl.sv
module acfCtrl
  import acfPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  fmtSel_t      fmtSel,
  input  logic         tblWrEn,
  input  logic         maskWrEn,
  input  logic         frmValid,
  input  logic         anyMatch,
  output ctrlStrobes_t strobes,
  output logic         hitValid
);
  logic fmtLegal;
  assign fmtLegal = (fmtSel != FMT_NONE);

  always_comb begin
    strobes.tblWe     = tblWrEn;
    strobes.maskWe    = maskWrEn;
    strobes.evalFrame = frmValid & fmtLegal;
    strobes.loadHit   = frmValid & fmtLegal & anyMatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) hitValid <= 1'b0;
    else       hitValid <= strobes.loadHit;
  end

  // R10: an accept pulse always follows a valid strobe
  assert_pulse_after_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> $past(frmValid));

  // R5: the disabled format never accepts
  assert_none_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && fmtSel == FMT_NONE) |=> !hitValid);
endmodule

// File: rtl/acfDatapath.sv
module acfDatapath
  import acfPkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int NUM_IMASK = 8,
  localparam int MAX_ENTRIES = 4 * NUM_WORDS,
  localparam int IDX_W   = $clog2(MAX_ENTRIES),
  localparam int WADDR_W = $clog2(NUM_WORDS),
  localparam int MADDR_W = $clog2(NUM_IMASK),
  localparam int CNT_W   = $clog2(NUM_IMASK + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  fmtSel_t            fmtSel,
  input  logic               indivEn,
  input  logic [CNT_W-1:0]   indivCount,
  input  logic [31:0]        globalMask,
  input  logic [WADDR_W-1:0] tblWrAddr,
  input  logic [31:0]        tblWrData,
  input  logic [MADDR_W-1:0] maskWrAddr,
  input  logic [31:0]        maskWrData,
  input  logic [28:0]        frmId,
  input  logic               frmExt,
  input  logic               frmRemote,
  output logic               anyMatch,
  output logic [IDX_W-1:0]   hitIndex
);
  logic [31:0] tblReg  [NUM_WORDS];
  logic [31:0] maskReg [NUM_IMASK];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < NUM_WORDS; w++) tblReg[w] <= '0;
    end else if (strobes.tblWe && (32'(tblWrAddr) < NUM_WORDS)) begin
      tblReg[tblWrAddr] <= tblWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int m = 0; m < NUM_IMASK; m++) maskReg[m] <= '0;
    end else if (strobes.maskWe && (32'(maskWrAddr) < NUM_IMASK)) begin
      maskReg[maskWrAddr] <= maskWrData;
    end
  end

  // Comparison keys, one per format
  logic [30:0] keyWhole;
  logic [13:0] keyHalf;
  logic [7:0]  keyQuarter;

  always_comb begin
    keyWhole   = {frmRemote, frmExt, (frmExt ? frmId : {18'b0, frmId[10:0]})};
    keyHalf    = {frmRemote, frmExt, (frmExt ? frmId[28:17] : {frmId[10:0], 1'b0})};
    keyQuarter = frmExt ? frmId[28:21] : frmId[10:3];
  end

  logic [MAX_ENTRIES-1:0] matchVec;

  for (genvar e = 0; e < MAX_ENTRIES; e++) begin : gEntry
    localparam int WH = e / 2;
    localparam int PH = e % 2;
    localparam int WQ = e / 4;
    localparam int PQ = e % 4;
    logic [31:0] maskWord;
    logic hitWhole, hitHalf, hitQuarter;

    if (e < NUM_IMASK) begin : gIndiv
      assign maskWord = (indivEn && (32'(e) < 32'(indivCount))) ? maskReg[e] : globalMask;
    end else begin : gGlobal
      assign maskWord = globalMask;
    end

    if (e < NUM_WORDS) begin : gWhole
      assign hitWhole = (((tblReg[e][30:0] ^ keyWhole) & maskWord[30:0]) == '0);
    end else begin : gNoWhole
      assign hitWhole = 1'b0;
    end

    if (e < 2 * NUM_WORDS) begin : gHalf
      assign hitHalf = (((tblReg[WH][14*PH +: 14] ^ keyHalf) & maskWord[14*PH +: 14]) == '0);
    end else begin : gNoHalf
      assign hitHalf = 1'b0;
    end

    assign hitQuarter = (((tblReg[WQ][8*PQ +: 8] ^ keyQuarter) & maskWord[8*PQ +: 8]) == '0);

    assign matchVec[e] = (fmtSel == FMT_WHOLE)   ? hitWhole :
                         (fmtSel == FMT_HALF)    ? hitHalf :
                         (fmtSel == FMT_QUARTER) ? hitQuarter : 1'b0;
  end

  // Lowest index wins
  logic [IDX_W-1:0] firstIdx;
  always_comb begin
    anyMatch = 1'b0;
    firstIdx = '0;
    for (int i = MAX_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyMatch = 1'b1;
        firstIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                hitIndex <= '0;
    else if (strobes.loadHit) hitIndex <= firstIdx;
  end

  // R11: index holds unless a frame is accepted
  assert_index_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadHit |=> $stable(hitIndex));

  // R1: an accepted index lies inside the active format's entry count
  assert_index_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadHit |-> ((fmtSel == FMT_WHOLE) ? (32'(firstIdx) < NUM_WORDS) :
                         (fmtSel == FMT_HALF)  ? (32'(firstIdx) < 2 * NUM_WORDS) : 1'b1));

  // R10: a load is only requested for a frame under evaluation
  assert_load_needs_eval_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadHit |-> strobes.evalFrame);
endmodule

// File: rtl/acfFilter.sv
module acfFilter
  import acfPkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int NUM_IMASK = 8,
  localparam int IDX_W   = $clog2(4 * NUM_WORDS),
  localparam int WADDR_W = $clog2(NUM_WORDS),
  localparam int MADDR_W = $clog2(NUM_IMASK),
  localparam int CNT_W   = $clog2(NUM_IMASK + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cfgFormat,
  input  logic               cfgIndivEn,
  input  logic [CNT_W-1:0]   cfgIndivCount,
  input  logic [31:0]        cfgGlobalMask,
  input  logic               tblWrEn,
  input  logic [WADDR_W-1:0] tblWrAddr,
  input  logic [31:0]        tblWrData,
  input  logic               maskWrEn,
  input  logic [MADDR_W-1:0] maskWrAddr,
  input  logic [31:0]        maskWrData,
  input  logic               frmValid,
  input  logic [28:0]        frmId,
  input  logic               frmExt,
  input  logic               frmRemote,
  output logic               hitValid,
  output logic [IDX_W-1:0]   hitIndex
);
  fmtSel_t      fmtSel;
  ctrlStrobes_t strobes;
  logic         anyMatch;

  assign fmtSel = fmtSel_t'(cfgFormat);

  acfCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fmtSel   (fmtSel),
    .tblWrEn  (tblWrEn),
    .maskWrEn (maskWrEn),
    .frmValid (frmValid),
    .anyMatch (anyMatch),
    .strobes  (strobes),
    .hitValid (hitValid)
  );

  acfDatapath #(
    .NUM_WORDS (NUM_WORDS),
    .NUM_IMASK (NUM_IMASK)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .fmtSel     (fmtSel),
    .indivEn    (cfgIndivEn),
    .indivCount (cfgIndivCount),
    .globalMask (cfgGlobalMask),
    .tblWrAddr  (tblWrAddr),
    .tblWrData  (tblWrData),
    .maskWrAddr (maskWrAddr),
    .maskWrData (maskWrData),
    .frmId      (frmId),
    .frmExt     (frmExt),
    .frmRemote  (frmRemote),
    .anyMatch   (anyMatch),
    .hitIndex   (hitIndex)
  );
endmodule

// File: tb/acfFilter_tb.sv
module acfFilter_tb;
  localparam int NW = 8;
  localparam int NI = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgFormat = 2'd0;
  logic        cfgIndivEn = 1'b0;
  logic [3:0]  cfgIndivCount = 4'd0;
  logic [31:0] cfgGlobalMask = 32'h0;
  logic        tblWrEn = 1'b0;
  logic [2:0]  tblWrAddr = 3'd0;
  logic [31:0] tblWrData = 32'h0;
  logic        maskWrEn = 1'b0;
  logic [2:0]  maskWrAddr = 3'd0;
  logic [31:0] maskWrData = 32'h0;
  logic        frmValid = 1'b0;
  logic [28:0] frmId = 29'h0;
  logic        frmExt = 1'b0;
  logic        frmRemote = 1'b0;
  logic        hitValid;
  logic [4:0]  hitIndex;

  always #5 clk = ~clk;

  acfFilter #(.NUM_WORDS(NW), .NUM_IMASK(NI)) u_dut (
    .clk(clk), .rstN(rstN), .cfgFormat(cfgFormat), .cfgIndivEn(cfgIndivEn),
    .cfgIndivCount(cfgIndivCount), .cfgGlobalMask(cfgGlobalMask),
    .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr), .tblWrData(tblWrData),
    .maskWrEn(maskWrEn), .maskWrAddr(maskWrAddr), .maskWrData(maskWrData),
    .frmValid(frmValid), .frmId(frmId), .frmExt(frmExt), .frmRemote(frmRemote),
    .hitValid(hitValid), .hitIndex(hitIndex)
  );

  int checks = 0;
  int bad = 0;
  int lastIdx = 0;
  logic [31:0] tblM [NW];
  logic [31:0] maskM [NI];
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic check(input bit ok, input string tag, input int actV, input int actI,
                       input int expV, input int expI);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: hitValid=%0d hitIndex=%0d expected hitValid=%0d hitIndex=%0d",
               tag, actV, actI, expV, expI);
    end
  endtask

  // Arithmetic model of the filter, from the requirements
  task automatic modelMatch(input logic [28:0] id, input logic ext, input logic rem,
                            output bit found, output int idx);
    int spw;
    found = 0; idx = 0;
    if (cfgFormat == 2'd3) return;
    spw = (cfgFormat == 2'd0) ? 1 : (cfgFormat == 2'd1) ? 2 : 4;
    for (int e = 0; e < NW * spw; e++) begin
      logic [31:0] mw, filt, key, m;
      int w, p;
      w = e / spw; p = e % spw;
      mw = (cfgIndivEn && e < int'(cfgIndivCount) && e < NI) ? maskM[e] : cfgGlobalMask;
      case (cfgFormat)
        2'd0: begin
          filt = tblM[w] & 32'h7FFF_FFFF;
          m    = mw & 32'h7FFF_FFFF;
          key  = {1'b0, rem, ext, (ext ? id : {18'b0, id[10:0]})};
        end
        2'd1: begin
          filt = (tblM[w] >> (14 * p)) & 32'h3FFF;
          m    = (mw >> (14 * p)) & 32'h3FFF;
          key  = {18'b0, rem, ext, (ext ? id[28:17] : {id[10:0], 1'b0})};
        end
        default: begin
          filt = (tblM[w] >> (8 * p)) & 32'hFF;
          m    = (mw >> (8 * p)) & 32'hFF;
          key  = {24'b0, (ext ? id[28:21] : id[10:3])};
        end
      endcase
      if (((filt ^ key) & m) == 32'h0) begin
        found = 1; idx = e;
        return;
      end
    end
  endtask

  task automatic writeTbl(input int w, input logic [31:0] d);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrAddr = 3'(w); tblWrData = d;
    @(negedge clk);
    tblWrEn = 1'b0;
    tblM[w] = d;
  endtask

  task automatic writeMask(input int m, input logic [31:0] d);
    @(negedge clk);
    maskWrEn = 1'b1; maskWrAddr = 3'(m); maskWrData = d;
    @(negedge clk);
    maskWrEn = 1'b0;
    maskM[m] = d;
  endtask

  task automatic sendFrame(input logic [28:0] id, input logic ext, input logic rem,
                           input string tag);
    bit ef; int ei;
    @(negedge clk);
    frmId = id; frmExt = ext; frmRemote = rem; frmValid = 1'b1;
    modelMatch(id, ext, rem, ef, ei);
    @(negedge clk);
    frmValid = 1'b0;
    if (ef) begin
      check(hitValid === 1'b1 && int'(hitIndex) == ei, tag, hitValid, hitIndex, 1, ei);
      lastIdx = ei;
    end else begin
      check(hitValid === 1'b0 && int'(hitIndex) == lastIdx, tag, hitValid, hitIndex, 0, lastIdx);
    end
  endtask

  task automatic sweepStd(input string tag);
    for (int i = 0; i < 2048; i++) begin
      logic [31:0] r;
      r = nextRand();
      sendFrame({r[17:0], 11'(i)}, 1'b0, 1'(i >> 5), tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) tblM[w] = 32'h0;
    for (int m = 0; m < NI; m++) maskM[m] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(hitValid === 1'b0 && hitIndex === 5'd0, "R11", hitValid, hitIndex, 0, 0);

    // Format 0: whole identifiers
    cfgFormat = 2'd0; cfgGlobalMask = 32'h7FFF_FFF0;
    for (int w = 0; w < NW; w++) begin
      logic [31:0] r;
      r = nextRand();
      if (w % 2 == 0) writeTbl(w, {21'b0, 11'(w * 150 + 7)});
      else            writeTbl(w, {1'b0, 1'(w == 3), 1'b1, r[28:0]});
    end
    sweepStd("R1/R2");
    for (int i = 0; i < 64; i++) begin
      int w; logic [31:0] r; logic [28:0] id;
      w = 2 * (i % 4) + 1; r = nextRand();
      id = tblM[w][28:0] ^ {25'b0, r[3:0]};
      if (i % 4 == 0) id = id ^ 29'h400;
      sendFrame(id, 1'b1, (i % 7 == 0) ? ~tblM[w][30] : tblM[w][30], "R2/R6");
    end

    // Format 1: two slots per word
    cfgFormat = 2'd1; cfgGlobalMask = {4'hF, 14'h3FF8, 14'h3FF8};
    for (int w = 0; w < NW; w++) begin
      logic [13:0] s [2];
      for (int k = 0; k < 2; k++) begin
        int e; logic [31:0] r;
        e = 2 * w + k; r = nextRand();
        s[k] = (e % 2 == 1) ? {1'b0, 1'b1, r[11:0]} : {1'(e == 4), 1'b0, 11'(e * 97 + 3), 1'b0};
      end
      writeTbl(w, {4'h0, s[1], s[0]});
    end
    sweepStd("R1/R3");
    for (int i = 0; i < 64; i++) begin
      int e; logic [31:0] r; logic [13:0] s; logic [28:0] id;
      e = 2 * (i % NW) + 1; r = nextRand();
      s = 14'((tblM[e / 2] >> (14 * (e % 2))) & 32'h3FFF);
      id = {s[11:0], r[16:0]};
      if (i % 4 == 0) id = id ^ 29'h0010_0000;
      sendFrame(id, 1'b1, s[13], "R3");
    end

    // Format 2: four slots per word
    cfgFormat = 2'd2; cfgGlobalMask = 32'hFCFC_FCFC;
    for (int w = 0; w < NW; w++)
      writeTbl(w, {8'(116 * w + 98), 8'(116 * w + 69), 8'(116 * w + 40), 8'(116 * w + 11)});
    sweepStd("R1/R4");
    for (int i = 0; i < 64; i++) begin
      int e; logic [31:0] r; logic [7:0] s; logic [28:0] id;
      e = i % (4 * NW); r = nextRand();
      s = 8'((tblM[e / 4] >> (8 * (e % 4))) & 32'hFF);
      id = {s, r[20:0]};
      if (i % 4 == 0) id = id ^ 29'h0040_0000;
      sendFrame(id, 1'b1, r[25], "R4");
    end

    // Format 3: nothing accepted
    cfgFormat = 2'd3;
    sweepStd("R5");

    // Individual masks on format 2
    cfgFormat = 2'd2; cfgGlobalMask = 32'hC0C0_C0C0;
    for (int m = 0; m < NI; m++) writeMask(m, 32'hFFFF_FFFF);
    cfgIndivEn = 1'b1; cfgIndivCount = 4'd3;
    sweepStd("R7");
    cfgIndivCount = 4'd12;
    sweepStd("R7");
    cfgIndivCount = 4'd0;
    sweepStd("R8");
    cfgIndivEn = 1'b0; cfgIndivCount = 4'd8;
    sweepStd("R8");

    // Priority: all entries match, lowest index wins
    cfgGlobalMask = 32'h0;
    for (int w = 0; w < NW; w++) writeTbl(w, 32'h0);
    sendFrame(29'h155, 1'b0, 1'b0, "R9/R6");
    check(hitIndex === 5'd0, "R9", hitValid, hitIndex, 1, 0);
    cfgGlobalMask = 32'hFFFF_FFFF;
    for (int w = 0; w < NW; w++) writeTbl(w, 32'h0505_0505);
    writeTbl(0, 32'h0);
    sendFrame(29'h028, 1'b0, 1'b0, "R9");
    check(hitIndex === 5'd4, "R9", hitValid, hitIndex, 1, 4);

    // Write then use, and single-cycle pulse
    cfgFormat = 2'd0; cfgGlobalMask = 32'h7FFF_FFFF;
    for (int w = 0; w < NW; w++) writeTbl(w, 32'h7FFF_FFFF);
    writeTbl(5, 32'h0000_0123);
    sendFrame(29'h123, 1'b0, 1'b0, "R12");
    check(hitIndex === 5'd5, "R12", hitValid, hitIndex, 1, 5);
    @(negedge clk);
    check(hitValid === 1'b0, "R10", hitValid, hitIndex, 0, 5);
    writeTbl(5, 32'h7FFF_FFFF);
    sendFrame(29'h123, 1'b0, 1'b0, "R12/R11");
    check(hitValid === 1'b0 && hitIndex === 5'd5, "R11", hitValid, hitIndex, 0, 5);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule